// File: doc/BRIEF.md
# Serial Transmitter with Enable Sequencing

This block turns 8-bit or 9-bit characters into asynchronous serial frames on a single output line that rests high. Each frame is a low start bit, the data bits least significant first, and a high stop bit. Every bit lasts a fixed number of baud ticks. A baud generator outside the block supplies the ticks.

Two enable bits, set through a small configuration write port, control the transmitter. The module-enable bit gates the whole transmitter. When it is cleared, the line is forced high at once, the transmitter drops to idle and the transmit-enable bit is cleared. The transmit-enable bit sequences the traffic:
- Setting it sends a run of ones one frame long before the first character.
- Clearing it lets the character in flight finish, then the line idles.
- Clearing it and setting it again during a character queues one frame-length run of ones behind that character.

Software hands characters to the block through a one-entry data register. An empty flag shows when that register can take the next character.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `dat_empty` is 1, both enable bits are clear, and nothing is transmitted until the transmit-enable bit is set.
- R2: A configuration write with `cfg_mod_en`=1 leaves the transmit-enable bit unchanged when the module-enable bit was clear before that write. A write with `cfg_mod_en`=0 clears both enable bits.
- R3: A write that changes transmit-enable from 0 to 1 starts a run of ones before any character. The run lasts 10 bit times when `nine_bit`=0 and 11 bit times when `nine_bit`=1. A pending character's start bit follows directly after the run.
- R4: A frame is bit 0 = start (0), then the data bits LSB first, then one stop bit (1). Each bit lasts `TICKS_PER_BIT` (16) baud ticks. With `nine_bit`=0, `dat_in[7:0]` is sent and the frame is 10 bits long.
- R5: With `nine_bit`=1, `dat_in[8:0]` is sent and the frame is 11 bits long.
- R6: A data write clears `dat_empty`. `dat_empty` sets in the cycle the character moves into the shift register. A data write in that same cycle takes priority.
- R7: When a character is pending at the end of a stop bit and transmit-enable is set, the next start bit follows with no idle gap.
- R8: Clearing transmit-enable during a character lets that character finish. The line then stays high, and a pending character stays pending (`dat_empty`=0).
- R9: Clearing and then setting transmit-enable during a character sends a run of ones one frame long right after that character, then the pending character.
- R10: Clearing module-enable forces `txd` high by the second clock edge after the write and abandons the frame. Transmission resumes only after a later 0-to-1 write of transmit-enable.
- R11: Bit timing advances only on cycles with `baud_tick` high. With a tick every third cycle, each bit lasts 48 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mod_en | input | 1 | Module-enable value written |
| cfg_tx_en | input | 1 | Transmit-enable value written |
| nine_bit | input | 1 | 1 = 9 data bits per frame, 0 = 8 |
| dat_we | input | 1 | Data register write strobe |
| dat_in | input | DATA_W (9) | Character to send |
| baud_tick | input | 1 | One pulse per baud sub-interval |
| dat_empty | output | 1 | Data register can take a new character |
| txd | output | 1 | Serial output, idle high |

## Verification
The bench measures the gap from an enabling write to the first start bit, to the cycle, in both character widths. A design whose preamble is one bit short or long, or that skips it, fails that count. It toggles the enable during a frame and expects exactly one frame of ones before the queued character. It also clears the enable mid-frame and expects the character to finish while the pending one stays untouched. A design that drops the queued idle, cuts the frame short or sends the pending byte would fail these checks. The bench also checks that an enable write made while the module is off is ignored. It checks that turning the module off raises the line at once, even in the middle of a run of zero bits. It checks that slowed baud ticks stretch every bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2
  } tx_state_t;
endpackage

// File: rtl/sertx_cfg.sv
module sertx_cfg (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic cfg_mod_en,
  input  logic cfg_tx_en,
  input  logic idle_take,
  output logic mod_en,
  output logic tx_en,
  output logic idle_pend
);
  logic te_rise;

  // a 0->1 transmit-enable write that is accepted
  assign te_rise = cfg_we && cfg_mod_en && mod_en && cfg_tx_en && !tx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_en    <= 1'b0;
      tx_en     <= 1'b0;
      idle_pend <= 1'b0;
    end else begin
      if (cfg_we) begin
        if (!cfg_mod_en) begin
          mod_en <= 1'b0;
          tx_en  <= 1'b0;
        end else begin
          mod_en <= 1'b1;
          if (mod_en) tx_en <= cfg_tx_en;
        end
      end
      if (!mod_en || (cfg_we && !cfg_mod_en)) idle_pend <= 1'b0;
      else if (te_rise)                      idle_pend <= 1'b1;
      else if (idle_take)                    idle_pend <= 1'b0;
    end
  end

  assert_te_gate_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> $past(mod_en));
  assert_te_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !mod_en |-> !tx_en);
endmodule

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  localparam int SUB_W = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_BIT - 1);

  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk) begin
    if (rst || !run)  sub_q <= '0;
    else if (tick)    sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);
  end

  assign bit_end = run && tick && (sub_q == SUB_LAST);

  assert_tick_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> (sub_q == $past(sub_q)));
  assert_sub_clear_R11: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sub_q == '0));
endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
  import sertx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_en,
  input  logic              tx_en,
  input  logic              idle_pend,
  input  logic              nine_bit,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_in,
  input  logic              bit_end,
  output logic              idle_take,
  output logic              run,
  output logic              txd,
  output logic              dat_empty
);
  localparam int FRM_W = DATA_W + 2;
  localparam int CNT_W = $clog2(FRM_W);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(FRM_W - 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(FRM_W - 2);

  tx_state_t         state_q;
  logic [FRM_W-1:0]  shreg_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [DATA_W-1:0] dat_q;
  logic              txd_q;
  logic              empty_q;

  logic [FRM_W-1:0]  frame;
  logic [CNT_W-1:0]  last_idx;
  logic              frame_last, boundary, go_pre, go_data, load;

  always_comb begin
    if (nine_bit) begin
      frame    = {1'b1, dat_q, 1'b0};
      last_idx = LAST_L;
    end else begin
      frame    = {2'b11, dat_q[DATA_W-2:0], 1'b0};
      last_idx = LAST_S;
    end
  end

  assign frame_last = bit_end && (bitcnt_q == last_idx);
  assign boundary   = (state_q == ST_IDLE) || frame_last;
  assign go_pre     = tx_en && idle_pend;
  assign go_data    = tx_en && !idle_pend && !empty_q;
  assign idle_take  = mod_en && boundary && go_pre;
  assign load       = mod_en && boundary && go_data;
  assign run        = (state_q != ST_IDLE);
  assign txd        = txd_q;
  assign dat_empty  = empty_q;

  // holding register
  always_ff @(posedge clk) begin
    if (rst) begin
      dat_q   <= '0;
      empty_q <= 1'b1;
    end else if (dat_we) begin
      dat_q   <= dat_in;
      empty_q <= 1'b0;
    end else if (load) begin
      empty_q <= 1'b1;
    end
  end

  // sequencer and shifter
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      txd_q    <= 1'b1;
    end else if (!mod_en) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      txd_q    <= 1'b1;
    end else if (boundary) begin
      bitcnt_q <= '0;
      if (go_pre) begin
        state_q <= ST_PRE;
        txd_q   <= 1'b1;
      end else if (go_data) begin
        state_q <= ST_DATA;
        txd_q   <= frame[0];
        shreg_q <= frame >> 1;
      end else begin
        state_q <= ST_IDLE;
        txd_q   <= 1'b1;
      end
    end else if (bit_end) begin
      bitcnt_q <= bitcnt_q + CNT_W'(1);
      if (state_q == ST_DATA) begin
        txd_q   <= shreg_q[0];
        shreg_q <= shreg_q >> 1;
      end else begin
        txd_q   <= 1'b1;
      end
    end
  end

  assert_empty_write_R6: assert property (@(posedge clk) disable iff (rst)
    dat_we |=> !empty_q);
  assert_ones_outside_frame_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_DATA) |-> txd_q);
  assert_modoff_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> (state_q == ST_IDLE) && txd_q);
  assert_bitcnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    bitcnt_q <= LAST_L);
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DATA_W        = 9,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_mod_en,
  input  logic              cfg_tx_en,
  input  logic              nine_bit,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_in,
  input  logic              baud_tick,
  output logic              dat_empty,
  output logic              txd
);
  logic mod_en, tx_en, idle_pend, idle_take, run, bit_end;

  sertx_cfg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_mod_en (cfg_mod_en),
    .cfg_tx_en  (cfg_tx_en),
    .idle_take  (idle_take),
    .mod_en     (mod_en),
    .tx_en      (tx_en),
    .idle_pend  (idle_pend)
  );

  sertx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .tick    (baud_tick),
    .bit_end (bit_end)
  );

  sertx_engine #(.DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .mod_en    (mod_en),
    .tx_en     (tx_en),
    .idle_pend (idle_pend),
    .nine_bit  (nine_bit),
    .dat_we    (dat_we),
    .dat_in    (dat_in),
    .bit_end   (bit_end),
    .idle_take (idle_take),
    .run       (run),
    .txd       (txd),
    .dat_empty (dat_empty)
  );
endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPB        = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0, cfg_mod_en = 1'b0, cfg_tx_en = 1'b0;
  logic       nine_bit = 1'b0;
  logic       dat_we = 1'b0;
  logic [8:0] dat_in = '0;
  logic       baud_tick = 1'b1;
  logic       dat_empty, txd;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int tcnt = 0;

  // {nine_bit, data}
  localparam logic [9:0] VEC [5] = '{
    {1'b0, 9'h0A5}, {1'b0, 9'h03C}, {1'b1, 9'h1F0}, {1'b1, 9'h00F}, {1'b0, 9'h0FF}
  };

  sertx_top dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mod_en(cfg_mod_en),
    .cfg_tx_en(cfg_tx_en), .nine_bit(nine_bit), .dat_we(dat_we),
    .dat_in(dat_in), .baud_tick(baud_tick), .dat_empty(dat_empty), .txd(txd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tick_div <= 1) baud_tick = 1'b1;
    else begin
      baud_tick = (tcnt == 0);
      tcnt = (tcnt + 1) % tick_div;
    end
  end

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic m, input logic t);
    cfg_mod_en = m; cfg_tx_en = t; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic data_write(input logic [8:0] d);
    dat_in = d; dat_we = 1'b1;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (txd !== 1'b0 && n < 5000);
  endtask

  // counts low samples over a window
  task automatic hold_high(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
  endtask

  function automatic logic exp_bit(input logic nb, input logic [8:0] d, input int i);
    int w = nb ? 9 : 8;
    if (i == 0) return 1'b0;
    if (i <= w) return d[i-1];
    return 1'b1;
  endfunction

  // called at the first negedge of a start bit; returns one frame later
  // act: 0 none, 1 write nxt, 2 write nxt + te off, 3 write nxt + te off/on
  task automatic check_frame(input logic nb, input logic [8:0] d, input int bw,
                             input string req, input int act, input logic [8:0] nxt);
    int fl = nb ? 11 : 10;
    int k = 0;
    if (act >= 1) begin data_write(nxt); k++; end
    if (act >= 2) begin cfg_write(1'b1, 1'b0); k++; end
    if (act == 3) begin cfg_write(1'b1, 1'b1); k++; end
    repeat (bw/2 - k) @(negedge clk);
    for (int i = 0; i < fl; i++) begin
      check(txd === exp_bit(nb, d, i), req, int'(txd), int'(exp_bit(nb, d, i)));
      if (i < fl - 1) repeat (bw) @(negedge clk);
    end
    repeat (bw/2) @(negedge clk);
  endtask

  initial begin
    int m, lows;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
    check(dat_empty === 1'b1, "R1 empty after reset", int'(dat_empty), 1);

    // R2: enable writes ignored with module off
    data_write(9'h055);
    cfg_write(1'b0, 1'b1);
    hold_high(300, lows);
    check(lows == 0, "R2 te write with module off", lows, 0);
    cfg_write(1'b1, 1'b1);
    hold_high(300, lows);
    check(lows == 0, "R2 te in module-on write ignored", lows, 0);
    check(dat_empty === 1'b0, "R1 data held pending", int'(dat_empty), 0);

    // vector table: R3 preamble, R4/R5 framing, R6 empty flag
    for (int v = 0; v < 5; v++) begin
      logic nb;
      logic [8:0] d;
      nb = VEC[v][9];
      d  = VEC[v][8:0];
      cfg_write(1'b1, 1'b0);
      nine_bit = nb;
      data_write(d);
      cfg_write(1'b1, 1'b1);
      wait_start(m);
      check(m == 1 + TPB * (nb ? 11 : 10), "R3 preamble length", m, 1 + TPB * (nb ? 11 : 10));
      check(dat_empty === 1'b1, "R6 empty set on load", int'(dat_empty), 1);
      check_frame(nb, d, TPB, nb ? "R5 nine-bit frame" : "R4 frame bits", 0, 9'h0);
      check(txd === 1'b1, "R4 line idle after stop", int'(txd), 1);
    end

    // R8: te cleared mid character
    cfg_write(1'b1, 1'b0);
    nine_bit = 1'b0;
    data_write(9'h0C9);
    cfg_write(1'b1, 1'b1);
    wait_start(m);
    check_frame(1'b0, 9'h0C9, TPB, "R8 frame completes", 2, 9'h1A6);
    check(dat_empty === 1'b0, "R6 write during frame clears empty", int'(dat_empty), 0);
    hold_high(300, lows);
    check(lows == 0, "R8 idle after disable", lows, 0);
    check(dat_empty === 1'b0, "R8 pending kept", int'(dat_empty), 0);

    // re-enable in nine-bit mode: R3 11-bit preamble
    nine_bit = 1'b1;
    cfg_write(1'b1, 1'b1);
    wait_start(m);
    check(m == 1 + TPB * 11, "R3 nine-bit preamble", m, 1 + TPB * 11);
    // R9: toggle during frame queues idle character
    check_frame(1'b1, 9'h1A6, TPB, "R5 frame after re-enable", 3, 9'h133);
    check(txd === 1'b1, "R9 no start right after toggle", int'(txd), 1);
    wait_start(m);
    check(m == TPB * 11, "R9 idle character length", m, TPB * 11);
    // R7: back-to-back
    check_frame(1'b1, 9'h133, TPB, "R9 pending after idle", 1, 9'h0AA);
    check(txd === 1'b0, "R7 no gap between frames", int'(txd), 0);
    check_frame(1'b1, 9'h0AA, TPB, "R7 second frame", 0, 9'h0);
    check(txd === 1'b1, "R7 idle after last", int'(txd), 1);

    // R10: module disable mid character
    cfg_write(1'b1, 1'b0);
    nine_bit = 1'b0;
    data_write(9'h000);
    cfg_write(1'b1, 1'b1);
    wait_start(m);
    cfg_write(1'b0, 1'b0);
    @(negedge clk);
    check(txd === 1'b1, "R10 txd forced high", int'(txd), 1);
    hold_high(200, lows);
    check(lows == 0, "R10 frame abandoned", lows, 0);
    data_write(9'h081);
    cfg_write(1'b1, 1'b1);
    hold_high(300, lows);
    check(lows == 0, "R10 te cleared by module off", lows, 0);
    check(dat_empty === 1'b0, "R10 data stays pending", int'(dat_empty), 0);
    cfg_write(1'b1, 1'b1);
    wait_start(m);
    check(m == 1 + TPB * 10, "R10 restart preamble", m, 1 + TPB * 10);
    check_frame(1'b0, 9'h081, TPB, "R10 frame after restart", 0, 9'h0);

    // R11: slow ticks
    tick_div = 3;
    cfg_write(1'b1, 1'b0);
    data_write(9'h0C3);
    cfg_write(1'b1, 1'b1);
    wait_start(m);
    check(m > 3 * TPB * 10 - 3 && m < 3 * TPB * 10 + 6, "R11 preamble in ticks", m, 3 * TPB * 10);
    check_frame(1'b0, 9'h0C3, 3 * TPB, "R11 bit width 48", 0, 9'h0);

    report();
  end
endmodule